// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block performs the state changes a processor core makes when it enters a general exception or an error-level event. A pipeline presents one exception request at a time. The request carries a type code, the faulting PC, a flag for a fault in a branch delay slot, a flag for a translation refill miss and a coprocessor number. The block also reads the core's current status word, cause word and exception base word. From these it computes the handler address and the new values of the exception PC, the error PC, the cause word and the status word.

The request side is a valid/ready stream. `exc_ready` is low while reset is asserted and on the first clock edge after reset is released. From then on it stays high, so the block accepts a request on every edge where `exc_valid` is high and never applies back-pressure. A request that is presented while `exc_ready` is low is dropped, so the source must hold it until it is accepted. All results are registered and appear in the cycle after acceptance. Each result comes with a one-cycle write strobe, and the surrounding core commits the new values to its architectural registers on that strobe. The data outputs keep their last value between strobes.

Top module: `exc_entry_ctrl`

## Requirements
- R1: `exc_ready` is 0 during reset and on the first edge after release, then 1. A request with `exc_valid` high is accepted only at an edge where `exc_ready` is 1. A request that is not accepted produces no strobe.
- R2: The strobes `upd_valid`, `exc_error`, `epc_we`, `errepc_we`, `cause_we` and `status_we` pulse for one cycle, exactly one cycle after the accepting edge. None of them rises without an accepted request.
- R3: For a general exception the handler base is 0xBFC00200 when status bit 22 (boot vectors) is 1. Otherwise the base is `ebase_i` with bits 9:0 cleared. `pc_next` is the base plus the offset.
- R4: The offset is 0x180 by default. An interrupt (type 0) uses 0x200 when cause bit 23 is 1. A TLB load or store (type 2 or 3) with `exc_refill` high and status bit 1 (exception level) clear uses 0x000. With the exception level set, a refill uses 0x180.
- R5: For the general types 0–13 and 15, the cause write places the type code in cause bits 6:2 and leaves the other cause bits as they were, except for the changes in R6 and R7.
- R6: When status bit 1 is clear, `epc_we` pulses and `epc_next` is the PC, or PC−4 when `exc_in_delay` is high. Cause bit 31 takes the value of `exc_in_delay`, and status bit 1 is set. When status bit 1 is set, no EPC write occurs and cause bit 31 is unchanged.
- R7: Type 11 (coprocessor unusable) writes `exc_cop` into cause bits 29:28. All other types leave those bits unchanged.
- R8: Type 16 (non-maskable) and type 17 (soft reset) write `errepc_next` with the PC, or PC−4 when in a delay slot. They set status bits 2 and 22, and they set status bit 19 (for type 16) or status bit 20 (for type 17). They send `pc_next` to 0xBFC00000 and produce no EPC or cause write.
- R9: Every accepted known request clears status bits 4:3, which selects kernel mode.
- R10: Types 14 and 18–31 pulse `exc_error` and produce no update strobe and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception request present |
| exc_ready | output | 1 | Request accepted at this edge when valid |
| exc_type | input | 5 | Exception type code |
| exc_pc | input | XLEN | PC of the faulting instruction |
| exc_in_delay | input | 1 | Fault occurred in a branch delay slot |
| exc_refill | input | 1 | Translation miss with no matching entry |
| exc_cop | input | 2 | Coprocessor number for type 11 |
| status_i | input | XLEN | Current status word |
| cause_i | input | XLEN | Current cause word |
| ebase_i | input | XLEN | Exception base word |
| upd_valid | output | 1 | Known request was taken; `pc_next` is valid |
| exc_error | output | 1 | Unknown type was rejected |
| pc_next | output | XLEN | Handler address |
| epc_we | output | 1 | Write strobe for the EPC |
| epc_next | output | XLEN | New EPC value |
| errepc_we | output | 1 | Write strobe for the error PC |
| errepc_next | output | XLEN | New error PC value |
| cause_we | output | 1 | Write strobe for the cause word |
| cause_next | output | XLEN | New cause word |
| status_we | output | 1 | Write strobe for the status word |
| status_next | output | XLEN | New status word |

## Verification
Every result of this block is due exactly one cycle after the accepting edge, because there is a single register stage between the request and the outputs. The bench drives each request on a falling edge and samples all outputs on the next falling edge, half a period after the edge that loaded them. Its reference model predicts for that same cycle which strobes fire and which values they carry. The strobes are compared every cycle. Each data output is compared only in cycles where its strobe is expected, because the data outputs hold their old value otherwise. The reference model also tracks the one-edge delay of `exc_ready` after reset, so a request offered on that first edge is expected to be dropped.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int TYPE_W = 5;
  localparam int CODE_W = 5;
  localparam int CE_W   = 2;

  typedef enum logic [1:0] {
    KIND_GENERAL = 2'd0,
    KIND_ERRLVL  = 2'd1,
    KIND_BAD     = 2'd2
  } exc_kind_e;

  // status word bit positions
  localparam int ST_EXL    = 1;
  localparam int ST_ERL    = 2;
  localparam int ST_KSU_LO = 3;
  localparam int ST_KSU_HI = 4;
  localparam int ST_NMI    = 19;
  localparam int ST_SR     = 20;
  localparam int ST_BEV    = 22;

  // cause word bit positions
  localparam int CA_CODE_LO = 2;
  localparam int CA_CODE_HI = 6;
  localparam int CA_IV      = 23;
  localparam int CA_CE_LO   = 28;
  localparam int CA_CE_HI   = 29;
  localparam int CA_BD      = 31;

  // type codes with special handling
  localparam logic [TYPE_W-1:0] T_INTR  = 5'd0;
  localparam logic [TYPE_W-1:0] T_TLB_L = 5'd2;
  localparam logic [TYPE_W-1:0] T_TLB_S = 5'd3;
  localparam logic [TYPE_W-1:0] T_COPU  = 5'd11;
  localparam logic [TYPE_W-1:0] T_GAP   = 5'd14;
  localparam logic [TYPE_W-1:0] T_LASTG = 5'd15;
  localparam logic [TYPE_W-1:0] T_NMI   = 5'd16;
  localparam logic [TYPE_W-1:0] T_SRST  = 5'd17;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [TYPE_W-1:0] typ,
  output exc_kind_e         kind,
  output logic              is_intr,
  output logic              is_tlb,
  output logic              is_copu,
  output logic              is_srst
);
  always_comb begin
    if ((typ <= T_LASTG) && (typ != T_GAP)) begin
      kind = KIND_GENERAL;
    end else if ((typ == T_NMI) || (typ == T_SRST)) begin
      kind = KIND_ERRLVL;
    end else begin
      kind = KIND_BAD;
    end
    is_intr = (typ == T_INTR);
    is_tlb  = (typ == T_TLB_L) || (typ == T_TLB_S);
    is_copu = (typ == T_COPU);
    is_srst = (typ == T_SRST);
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              ALIGN_BITS = 10,
  parameter logic [XLEN-1:0] BOOT_BASE  = XLEN'(32'hBFC0_0200),
  parameter logic [XLEN-1:0] ERR_VEC    = XLEN'(32'hBFC0_0000),
  parameter logic [XLEN-1:0] OFF_DEF    = XLEN'(32'h180),
  parameter logic [XLEN-1:0] OFF_INTR   = XLEN'(32'h200),
  parameter logic [XLEN-1:0] OFF_REFILL = XLEN'(32'h000)
) (
  input  exc_kind_e         kind,
  input  logic              is_intr,
  input  logic              is_tlb,
  input  logic              refill,
  input  logic              exl,
  input  logic              bev,
  input  logic              iv,
  input  logic [XLEN-1:0]   ebase,
  output logic [XLEN-1:0]   target
);
  localparam logic [XLEN-1:0] ALIGN_MASK = XLEN'((64'd1 << ALIGN_BITS) - 64'd1);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base = bev ? BOOT_BASE : (ebase & ~ALIGN_MASK);
    if (is_intr && iv) begin
      offset = OFF_INTR;
    end else if (is_tlb && refill && !exl) begin
      offset = OFF_REFILL;
    end else begin
      offset = OFF_DEF;
    end
    target = (kind == KIND_ERRLVL) ? ERR_VEC : (base + offset);
  end
endmodule

// File: rtl/exc_state_next.sv
module exc_state_next
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  exc_kind_e         kind,
  input  logic [TYPE_W-1:0] typ,
  input  logic              is_copu,
  input  logic              is_srst,
  input  logic [XLEN-1:0]   pc,
  input  logic              in_delay,
  input  logic [CE_W-1:0]   cop,
  input  logic [XLEN-1:0]   status_cur,
  input  logic [XLEN-1:0]   cause_cur,
  output logic              epc_wr,
  output logic [XLEN-1:0]   epc_val,
  output logic              errepc_wr,
  output logic [XLEN-1:0]   errepc_val,
  output logic              cause_wr,
  output logic [XLEN-1:0]   cause_val,
  output logic              status_wr,
  output logic [XLEN-1:0]   status_val
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] resume_pc;
  logic            exl_now;

  assign resume_pc = in_delay ? (pc - STEP) : pc;
  assign exl_now   = status_cur[ST_EXL];

  always_comb begin
    epc_wr     = 1'b0;
    errepc_wr  = 1'b0;
    cause_wr   = 1'b0;
    status_wr  = 1'b0;
    epc_val    = resume_pc;
    errepc_val = resume_pc;
    cause_val  = cause_cur;
    status_val = status_cur;
    unique case (kind)
      KIND_GENERAL: begin
        cause_wr  = 1'b1;
        status_wr = 1'b1;
        cause_val[CA_CODE_HI:CA_CODE_LO] = typ[CODE_W-1:0];
        if (is_copu) begin
          cause_val[CA_CE_HI:CA_CE_LO] = cop;
        end
        if (!exl_now) begin
          epc_wr             = 1'b1;
          cause_val[CA_BD]   = in_delay;
          status_val[ST_EXL] = 1'b1;
        end
        status_val[ST_KSU_HI:ST_KSU_LO] = 2'b00;
      end
      KIND_ERRLVL: begin
        errepc_wr          = 1'b1;
        status_wr          = 1'b1;
        status_val[ST_ERL] = 1'b1;
        status_val[ST_BEV] = 1'b1;
        if (is_srst) begin
          status_val[ST_SR] = 1'b1;
        end else begin
          status_val[ST_NMI] = 1'b1;
        end
        status_val[ST_KSU_HI:ST_KSU_LO] = 2'b00;
      end
      default: begin
      end
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4,
  parameter int ALIGN_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  output logic              exc_ready,
  input  logic [TYPE_W-1:0] exc_type,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic              exc_in_delay,
  input  logic              exc_refill,
  input  logic [CE_W-1:0]   exc_cop,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   cause_i,
  input  logic [XLEN-1:0]   ebase_i,
  output logic              upd_valid,
  output logic              exc_error,
  output logic [XLEN-1:0]   pc_next,
  output logic              epc_we,
  output logic [XLEN-1:0]   epc_next,
  output logic              errepc_we,
  output logic [XLEN-1:0]   errepc_next,
  output logic              cause_we,
  output logic [XLEN-1:0]   cause_next,
  output logic              status_we,
  output logic [XLEN-1:0]   status_next
);
  exc_kind_e       kind;
  logic            is_intr, is_tlb, is_copu, is_srst;
  logic [XLEN-1:0] target;
  logic            n_epc_wr, n_err_wr, n_cause_wr, n_status_wr;
  logic [XLEN-1:0] n_epc, n_err, n_cause, n_status;
  logic            ready_q;
  logic            accept, known;

  exc_classify u_class (
    .typ     (exc_type),
    .kind    (kind),
    .is_intr (is_intr),
    .is_tlb  (is_tlb),
    .is_copu (is_copu),
    .is_srst (is_srst)
  );

  exc_vector_sel #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_vec (
    .kind    (kind),
    .is_intr (is_intr),
    .is_tlb  (is_tlb),
    .refill  (exc_refill),
    .exl     (status_i[ST_EXL]),
    .bev     (status_i[ST_BEV]),
    .iv      (cause_i[CA_IV]),
    .ebase   (ebase_i),
    .target  (target)
  );

  exc_state_next #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_next (
    .kind       (kind),
    .typ        (exc_type),
    .is_copu    (is_copu),
    .is_srst    (is_srst),
    .pc         (exc_pc),
    .in_delay   (exc_in_delay),
    .cop        (exc_cop),
    .status_cur (status_i),
    .cause_cur  (cause_i),
    .epc_wr     (n_epc_wr),
    .epc_val    (n_epc),
    .errepc_wr  (n_err_wr),
    .errepc_val (n_err),
    .cause_wr   (n_cause_wr),
    .cause_val  (n_cause),
    .status_wr  (n_status_wr),
    .status_val (n_status)
  );

  assign exc_ready = ready_q;
  assign accept    = exc_valid && ready_q;
  assign known     = (kind != KIND_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      upd_valid   <= 1'b0;
      exc_error   <= 1'b0;
      epc_we      <= 1'b0;
      errepc_we   <= 1'b0;
      cause_we    <= 1'b0;
      status_we   <= 1'b0;
      pc_next     <= '0;
      epc_next    <= '0;
      errepc_next <= '0;
      cause_next  <= '0;
      status_next <= '0;
    end else begin
      ready_q   <= 1'b1;
      upd_valid <= accept && known;
      exc_error <= accept && !known;
      epc_we    <= accept && n_epc_wr;
      errepc_we <= accept && n_err_wr;
      cause_we  <= accept && n_cause_wr;
      status_we <= accept && n_status_wr;
      if (accept && known)       pc_next     <= target;
      if (accept && n_epc_wr)    epc_next    <= n_epc;
      if (accept && n_err_wr)    errepc_next <= n_err;
      if (accept && n_cause_wr)  cause_next  <= n_cause;
      if (accept && n_status_wr) status_next <= n_status;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_valid,
  input logic            exc_ready,
  input logic [XLEN-1:0] exc_pc,
  input logic            exc_in_delay,
  input logic [XLEN-1:0] status_i,
  input logic            upd_valid,
  input logic            exc_error,
  input logic            epc_we,
  input logic [XLEN-1:0] epc_next,
  input logic            errepc_we,
  input logic            cause_we,
  input logic [XLEN-1:0] cause_next,
  input logic            status_we,
  input logic [XLEN-1:0] status_next
);
  // R1: once raised, ready stays high while out of reset
  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ready |=> exc_ready);

  // R2: a strobe needs an accepted request one cycle earlier
  a_r2_strobe_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid || exc_error) |-> $past(exc_valid && exc_ready));

  // R2: update and error never together
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_valid, exc_error}));

  // R6: EPC written only from a clear exception level, and it sets the level
  a_r6_epc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |-> ($past(status_i[1]) == 1'b0) && status_next[1] && cause_we);

  // R6: EPC rewinds by one instruction in a delay slot, BD follows the flag
  a_r6_epc_value: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |-> (epc_next == ($past(exc_in_delay) ? $past(exc_pc) - 4 : $past(exc_pc)))
               && (cause_next[31] == $past(exc_in_delay)));

  // R8: error-level path raises ERL and BEV and touches neither EPC nor cause
  a_r8_err_path: assert property (@(posedge clk) disable iff (!rst_n)
    errepc_we |-> status_next[2] && status_next[22] && !epc_we && !cause_we);

  // R9: every status write selects kernel mode
  a_r9_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |-> (status_next[4:3] == 2'b00));

  // R10: a rejected type writes nothing
  a_r10_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    exc_error |-> !(epc_we || errepc_we || cause_we || status_we));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .exc_valid    (exc_valid),
  .exc_ready    (exc_ready),
  .exc_pc       (exc_pc),
  .exc_in_delay (exc_in_delay),
  .status_i     (status_i),
  .upd_valid    (upd_valid),
  .exc_error    (exc_error),
  .epc_we       (epc_we),
  .epc_next     (epc_next),
  .errepc_we    (errepc_we),
  .cause_we     (cause_we),
  .cause_next   (cause_next),
  .status_we    (status_we),
  .status_next  (status_next)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic        exc_ready;
  logic [4:0]  exc_type = '0;
  logic [31:0] exc_pc = '0;
  logic        exc_in_delay = 1'b0;
  logic        exc_refill = 1'b0;
  logic [1:0]  exc_cop = '0;
  logic [31:0] status_i = '0;
  logic [31:0] cause_i = '0;
  logic [31:0] ebase_i = '0;
  logic        upd_valid, exc_error, epc_we, errepc_we, cause_we, status_we;
  logic [31:0] pc_next, epc_next, errepc_next, cause_next, status_next;

  int checks = 0;
  int fails  = 0;
  bit ready_m = 1'b0;

  always #5 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_ready(exc_ready),
    .exc_type(exc_type), .exc_pc(exc_pc), .exc_in_delay(exc_in_delay),
    .exc_refill(exc_refill), .exc_cop(exc_cop), .status_i(status_i),
    .cause_i(cause_i), .ebase_i(ebase_i), .upd_valid(upd_valid),
    .exc_error(exc_error), .pc_next(pc_next), .epc_we(epc_we),
    .epc_next(epc_next), .errepc_we(errepc_we), .errepc_next(errepc_next),
    .cause_we(cause_we), .cause_next(cause_next), .status_we(status_we),
    .status_next(status_next)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge, predict, sample at the next falling edge.
  task automatic step(input string tag, input bit v, input logic [4:0] t,
                      input logic [31:0] pc, input bit ds, input bit rf,
                      input logic [1:0] cp, input logic [31:0] st,
                      input logic [31:0] ca, input logic [31:0] eb);
    bit acc, e_upd, e_err, e_epcwe, e_errwe, e_cawe, e_stwe;
    logic [31:0] e_pc, e_epc, e_errpc, e_ca, e_st, base, off;
    exc_valid = v; exc_type = t; exc_pc = pc; exc_in_delay = ds;
    exc_refill = rf; exc_cop = cp; status_i = st; cause_i = ca; ebase_i = eb;
    acc = v && ready_m;
    {e_upd, e_err, e_epcwe, e_errwe, e_cawe, e_stwe} = '0;
    e_pc = '0; e_epc = '0; e_errpc = '0; e_ca = ca; e_st = st;
    if (acc) begin
      if (t <= 5'd13 || t == 5'd15) begin
        e_upd = 1; e_cawe = 1; e_stwe = 1;
        base = st[22] ? 32'hBFC00200 : {eb[31:10], 10'b0};
        off = 32'h180;
        if (t == 5'd0 && ca[23]) off = 32'h200;
        if ((t == 5'd2 || t == 5'd3) && rf && !st[1]) off = 32'h0;
        e_pc = base + off;
        e_ca[6:2] = t;
        if (t == 5'd11) e_ca[29:28] = cp;
        e_st[4:3] = 2'b00;
        if (!st[1]) begin
          e_epcwe = 1; e_epc = ds ? pc - 32'd4 : pc;
          e_ca[31] = ds; e_st[1] = 1'b1;
        end
      end else if (t == 5'd16 || t == 5'd17) begin
        e_upd = 1; e_errwe = 1; e_stwe = 1;
        e_errpc = ds ? pc - 32'd4 : pc;
        e_st[2] = 1'b1; e_st[22] = 1'b1; e_st[4:3] = 2'b00;
        if (t == 5'd16) e_st[19] = 1'b1; else e_st[20] = 1'b1;
        e_pc = 32'hBFC00000;
      end else begin
        e_err = 1;
      end
    end
    @(negedge clk);
    if (rst_n) ready_m = 1'b1;
    check(tag, "strobes", {26'd0, upd_valid, exc_error, epc_we, errepc_we, cause_we, status_we},
          {26'd0, e_upd, e_err, e_epcwe, e_errwe, e_cawe, e_stwe});
    check("R1", "ready", {31'd0, exc_ready}, {31'd0, ready_m});
    if (e_upd)   check(tag, "pc_next", pc_next, e_pc);
    if (e_epcwe) check(tag, "epc_next", epc_next, e_epc);
    if (e_errwe) check(tag, "errepc_next", errepc_next, e_errpc);
    if (e_cawe)  check(tag, "cause_next", cause_next, e_ca);
    if (e_stwe)  check(tag, "status_next", status_next, e_st);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset ready", {31'd0, exc_ready}, 32'd0);
    check("R2", "reset strobes", {26'd0, upd_valid, exc_error, epc_we, errepc_we, cause_we, status_we}, 32'd0);
    rst_n = 1'b1;
    // R1: first edge after release drops the request
    step("R1", 1, 5'd8, 32'h0040_0100, 0, 0, 2'd0, 32'h0000_0010, 32'h0, 32'h8000_1234);
    // R3 R5 R6 R9: syscall, base from ebase, user mode cleared
    step("R3", 1, 5'd8, 32'h0040_0100, 0, 0, 2'd0, 32'h0000_0010, 32'h0, 32'h8000_1234);
    // R4: interrupt with IV under boot vectors
    step("R4", 1, 5'd0, 32'h0000_2000, 0, 0, 2'd0, 32'h0040_0000, 32'h0080_0000, 32'h8000_0000);
    // R4: interrupt without IV
    step("R4", 1, 5'd0, 32'h0000_2000, 0, 0, 2'd0, 32'h0, 32'h0, 32'h9000_0000);
    // R4: refill load from clear exception level
    step("R4", 1, 5'd2, 32'h0000_3000, 0, 1, 2'd0, 32'h0, 32'h0, 32'h9000_03FF);
    // R4 R6: refill store with exception level set, BD kept
    step("R6", 1, 5'd3, 32'h0000_3000, 1, 1, 2'd0, 32'h0000_0002, 32'h8000_0000, 32'h9000_0000);
    // R4: refill store with clear level under boot vectors
    step("R4", 1, 5'd3, 32'h0000_3004, 0, 1, 2'd0, 32'h0040_0000, 32'h0, 32'h0);
    // R6: delay slot rewinds
    step("R6", 1, 5'd9, 32'h0000_1000, 1, 0, 2'd0, 32'h0, 32'h0, 32'h8000_0000);
    // R7: coprocessor unusable
    step("R7", 1, 5'd11, 32'h0000_1100, 0, 0, 2'd3, 32'h0, 32'h0, 32'h8000_0000);
    // R7: CE kept for other types
    step("R7", 1, 5'd12, 32'h0000_1200, 0, 0, 2'd1, 32'h0, 32'h2000_0000, 32'h8000_0000);
    // R5: code 15 and code 13, back to back (R2)
    step("R5", 1, 5'd15, 32'h0000_1300, 0, 0, 2'd0, 32'h0, 32'hFFFF_FF83, 32'h8000_0000);
    step("R2", 1, 5'd13, 32'h0000_1304, 0, 0, 2'd0, 32'h0, 32'h0, 32'h8000_0000);
    // R8: non-maskable in delay slot, and soft reset
    step("R8", 1, 5'd16, 32'h0000_4000, 1, 0, 2'd0, 32'h0000_0018, 32'h1234_0000, 32'h8000_0000);
    step("R8", 1, 5'd17, 32'h0000_5000, 0, 0, 2'd0, 32'h0000_0002, 32'h0, 32'h8000_0000);
    // R10: unknown types
    step("R10", 1, 5'd14, 32'h0000_6000, 0, 0, 2'd0, 32'h0, 32'h0, 32'h8000_0000);
    step("R10", 1, 5'd20, 32'h0000_6000, 1, 0, 2'd0, 32'h0, 32'h0, 32'h8000_0000);
    // R2: idle cycles produce nothing
    step("R2", 0, 5'd8, 32'h0000_7000, 0, 0, 2'd0, 32'h0, 32'h0, 32'h8000_0000);
    step("R2", 0, 5'd16, 32'h0000_7000, 0, 0, 2'd0, 32'h0, 32'h0, 32'h8000_0000);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule